// File: doc/BRIEF.md
# Interrupt Register Bank Stack

This block keeps a processor's register context in hardware across nested interrupts. When the core accepts an interrupt that is allowed to use banks, the block copies the complete working set in a single clock cycle into the bank chosen by its bank number and then moves the bank number up by one. The working set is fifteen general registers, the global base register, the high and low halves of the multiply-accumulate result, the procedure (return) register and the vector table offset of the interrupt being taken. When the core returns from an interrupt handler, a restore strobe moves the bank number down by one and presents the contents of that bank on the restore outputs. The banks therefore behave as a last-in first-out stack: the lowest bank is written first and the latest bank written is returned first.

The bank number is visible to the core at all times. Two sticky flags record misuse. One records a save attempted with every bank occupied. The other records a restore attempted with no bank occupied. Neither attempt changes any stored state. The surrounding interrupt controller decides which interrupts qualify for banking and drives the enable qualifier together with the save strobe.

Top module: `reg_bank_stack`

## Requirements
- R1: After a synchronous active-low reset, the bank number is 0, both flags are 0 and every restore output is 0.
- R2: A save strobe with the bank enable high and a bank number below 15 stores the whole input context in bank[bank number]. The bank number is one higher after that clock edge.
- R3: A save strobe with the bank enable low changes neither the bank number, the flags, the stored banks nor the restore outputs.
- R4: A restore strobe without a save strobe and with a bank number above 0 lowers the bank number by one. After the same edge, the restore outputs show the bank now selected.
- R5: A qualified save at bank number 15 stores nothing and leaves the bank number at 15. It sets the overflow flag.
- R6: A restore at bank number 0 leaves the bank number and the restore outputs unchanged. It sets the underflow flag.
- R7: When save and restore strobes are high in the same cycle, the restore is ignored and the save proceeds as in R2, R3 or R5.
- R8: Every field is returned bit-exact: general registers 0 to 14 on bits [32*i+31:32*i] of the general-register bus, plus the global base, multiply-high, multiply-low, procedure and vector-offset words.
- R9: The overflow and underflow flags stay set until reset.
- R10: Fifteen qualified saves followed by fifteen restores return the contexts in exactly the reverse order of saving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| save_req | input | 1 | Interrupt accepted; save context this cycle |
| bank_en | input | 1 | Accepted interrupt may use a bank |
| restore_req | input | 1 | Return from handler; restore the latest bank |
| gpr_in | input | 480 | General registers 0..14, register i on bits [32*i+31:32*i] |
| gbr_in | input | 32 | Global base register to save |
| mach_in | input | 32 | Multiply-accumulate high word to save |
| macl_in | input | 32 | Multiply-accumulate low word to save |
| pr_in | input | 32 | Procedure register to save |
| vto_in | input | 32 | Vector table offset of the accepted interrupt |
| gpr_out | output | 480 | Restored general registers, same layout as gpr_in |
| gbr_out | output | 32 | Restored global base register |
| mach_out | output | 32 | Restored multiply-accumulate high word |
| macl_out | output | 32 | Restored multiply-accumulate low word |
| pr_out | output | 32 | Restored procedure register |
| vto_out | output | 32 | Restored vector table offset |
| bank_num | output | 5 | Number of banks in use, 0..15 |
| overflow | output | 1 | Sticky: save attempted with all banks full |
| underflow | output | 1 | Sticky: restore attempted with no bank in use |

## Verification
The assertions assume that the strobes are clean single-cycle levels sampled at the rising edge and that the context inputs are stable at that edge. They also assume that the bank enable is meaningful only while a save strobe is present. The stimulus drives every input on the falling edge and holds it for a whole cycle. It combines the strobes in all the ways that matter: qualified and unqualified saves, lone restores, and simultaneous save and restore. It also deliberately runs the stack past both ends, so the overflow and underflow paths are reached from legal inputs and not from undefined ones.

// File: rtl/rbs_pkg.sv
// Package: shared definitions for the register bank stack.
// Assumes: nothing; holds only types used across the submodules.
package rbs_pkg;

    // Operation chosen by the pointer controller for the current cycle.
    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_SAVE    = 3'd1,
        OP_RESTORE = 3'd2,
        OP_OVF     = 3'd3,
        OP_UDF     = 3'd4
    } rbs_op_e;

endpackage

// File: rtl/rbs_ptr_ctrl.sv
// Module: rbs_ptr_ctrl
// Decodes the save/restore strobes into one operation per cycle, keeps the
// bank number and the sticky misuse flags, and produces write/read indices.
// Assumes: strobes are synchronous to clk; save has priority over restore.
module rbs_ptr_ctrl
    import rbs_pkg::*;
#(
    parameter int NUM_BANKS = 15,
    parameter int BN_W      = 5,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic             bank_en,
    input  logic             restore_req,
    output rbs_op_e          op,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [BN_W-1:0]  bn,
    output logic             ovf_flag,
    output logic             udf_flag
);

    localparam logic [BN_W-1:0] BN_FULL  = BN_W'(NUM_BANKS);
    localparam logic [BN_W-1:0] BN_EMPTY = '0;

    logic             is_full;
    logic             is_empty;
    logic [BN_W-1:0]  bn_dec;

    assign is_full  = (bn == BN_FULL);
    assign is_empty = (bn == BN_EMPTY);
    assign bn_dec   = bn - BN_W'(1);

    // Select this cycle's operation; save wins over restore.
    always_comb begin
        op = OP_IDLE;
        if (save_req) begin
            if (bank_en) begin
                op = is_full ? OP_OVF : OP_SAVE;
            end
        end else if (restore_req) begin
            op = is_empty ? OP_UDF : OP_RESTORE;
        end
    end

    // Indices into the bank array: write at bn, read at bn-1.
    always_comb begin
        wr_idx = bn[IDX_W-1:0];
        rd_idx = bn_dec[IDX_W-1:0];
    end

    // Bank number register: step up on save, down on restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bn <= BN_EMPTY;
        end else begin
            unique case (op)
                OP_SAVE:    bn <= bn + BN_W'(1);
                OP_RESTORE: bn <= bn_dec;
                default:    bn <= bn;
            endcase
        end
    end

    // Sticky misuse flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            if (op == OP_OVF) ovf_flag <= 1'b1;
            if (op == OP_UDF) udf_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/rbs_bank_array.sv
// Module: rbs_bank_array
// Storage for NUM_BANKS context words, each CTX_W bits wide, with one
// write port and one combinational read port.
// Assumes: rd_idx is only consumed when it points at a written bank, so
// the storage itself is not reset.
module rbs_bank_array #(
    parameter int NUM_BANKS = 15,
    parameter int CTX_W     = 640,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CTX_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTX_W-1:0] rd_data
);

    logic [CTX_W-1:0] bank_q [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [CTX_W-1:0] slot_q;

        // Capture the whole context when this bank is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q <= wr_data;
            end
        end

        assign bank_q[g] = slot_q;
    end

    // Read mux; an index outside the array yields zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = bank_q[i];
        end
    end

endmodule

// File: rtl/rbs_restore_reg.sv
// Module: rbs_restore_reg
// Holds the most recently restored context on the block outputs.
// Assumes: load is asserted only for a valid restore.
module rbs_restore_reg #(
    parameter int CTX_W = 640
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CTX_W-1:0] din,
    output logic [CTX_W-1:0] dout
);

    // Load restored context; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/reg_bank_stack.sv
// Module: reg_bank_stack (top)
// Hardware save/restore of a processor register context in a stack of
// banks. Packs the input fields into one context word, routes it to the
// bank array, and unpacks the restored context to the outputs.
// Assumes: save_req is qualified by bank_en from the interrupt logic;
// context inputs are valid in the save cycle.
module reg_bank_stack
    import rbs_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_GPR   = 15,
    parameter int NUM_BANKS = 15,
    parameter int BN_W      = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      save_req,
    input  logic                      bank_en,
    input  logic                      restore_req,
    input  logic [NUM_GPR*DATA_W-1:0] gpr_in,
    input  logic [DATA_W-1:0]         gbr_in,
    input  logic [DATA_W-1:0]         mach_in,
    input  logic [DATA_W-1:0]         macl_in,
    input  logic [DATA_W-1:0]         pr_in,
    input  logic [DATA_W-1:0]         vto_in,
    output logic [NUM_GPR*DATA_W-1:0] gpr_out,
    output logic [DATA_W-1:0]         gbr_out,
    output logic [DATA_W-1:0]         mach_out,
    output logic [DATA_W-1:0]         macl_out,
    output logic [DATA_W-1:0]         pr_out,
    output logic [DATA_W-1:0]         vto_out,
    output logic [BN_W-1:0]           bank_num,
    output logic                      overflow,
    output logic                      underflow
);

    localparam int GPR_W = NUM_GPR * DATA_W;
    localparam int CTX_W = GPR_W + 5 * DATA_W;
    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    rbs_op_e          op;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [CTX_W-1:0] save_bus;
    logic [CTX_W-1:0] rd_bus;
    logic [CTX_W-1:0] restore_bus;

    // Pack input fields: GPRs lowest, vector offset highest.
    always_comb begin
        save_bus = {vto_in, pr_in, macl_in, mach_in, gbr_in, gpr_in};
    end

    rbs_ptr_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .BN_W      (BN_W),
        .IDX_W     (IDX_W)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .bank_en     (bank_en),
        .restore_req (restore_req),
        .op          (op),
        .wr_idx      (wr_idx),
        .rd_idx      (rd_idx),
        .bn          (bank_num),
        .ovf_flag    (overflow),
        .udf_flag    (underflow)
    );

    rbs_bank_array #(
        .NUM_BANKS (NUM_BANKS),
        .CTX_W     (CTX_W),
        .IDX_W     (IDX_W)
    ) u_banks (
        .clk     (clk),
        .wr_en   (op == OP_SAVE),
        .wr_idx  (wr_idx),
        .wr_data (save_bus),
        .rd_idx  (rd_idx),
        .rd_data (rd_bus)
    );

    rbs_restore_reg #(
        .CTX_W (CTX_W)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (op == OP_RESTORE),
        .din   (rd_bus),
        .dout  (restore_bus)
    );

    // Unpack the restored context onto the field outputs.
    always_comb begin
        gpr_out  = restore_bus[GPR_W-1:0];
        gbr_out  = restore_bus[GPR_W + 1*DATA_W - 1 -: DATA_W];
        mach_out = restore_bus[GPR_W + 2*DATA_W - 1 -: DATA_W];
        macl_out = restore_bus[GPR_W + 3*DATA_W - 1 -: DATA_W];
        pr_out   = restore_bus[GPR_W + 4*DATA_W - 1 -: DATA_W];
        vto_out  = restore_bus[GPR_W + 5*DATA_W - 1 -: DATA_W];
    end

endmodule

// File: rtl/rbs_checker.sv
// Module: rbs_checker
// Temporal properties of the register bank stack, bound into the top.
// Assumes: strobes are sampled at the rising edge of clk.
module rbs_checker #(
    parameter int NUM_BANKS = 15,
    parameter int BN_W      = 5,
    parameter int CTX_W     = 640
) (
    input logic             clk,
    input logic             rst_n,
    input logic             save_req,
    input logic             bank_en,
    input logic             restore_req,
    input logic [BN_W-1:0]  bank_num,
    input logic             overflow,
    input logic             underflow,
    input logic [CTX_W-1:0] ctx_out
);

    localparam logic [BN_W-1:0] FULL = BN_W'(NUM_BANKS);

    // R1: bank number never leaves 0..NUM_BANKS
    a_r1_bn_range: assert property (@(posedge clk) disable iff (!rst_n)
        bank_num <= FULL);

    // R2: qualified save below full steps the bank number up
    a_r2_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && bank_en && bank_num != FULL) |=> (bank_num == $past(bank_num) + BN_W'(1)));

    // R3: unqualified save leaves the bank number alone
    a_r3_unqualified_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !bank_en) |=> $stable(bank_num));

    // R4: restore above empty steps the bank number down
    a_r4_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && bank_num != '0) |=> (bank_num == $past(bank_num) - BN_W'(1)));

    // R5: save at full holds the number and raises overflow
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && bank_en && bank_num == FULL) |=> (bank_num == FULL && overflow));

    // R6: restore at empty holds number and outputs, raises underflow
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && bank_num == '0) |=> (bank_num == '0 && underflow && $stable(ctx_out)));

    // R7: a restore masked by a save leaves outputs unchanged
    a_r7_save_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> $stable(ctx_out));

    // R9: flags are sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

endmodule

bind reg_bank_stack rbs_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BN_W      (BN_W),
    .CTX_W     (CTX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .bank_en     (bank_en),
    .restore_req (restore_req),
    .bank_num    (bank_num),
    .overflow    (overflow),
    .underflow   (underflow),
    .ctx_out     (restore_bus)
);

// File: tb/sim_reg_bank_stack.sv
`timescale 1ns/1ps
// Bench for reg_bank_stack: a behavioural queue model updated each clock
// and compared against every output after every edge.
module sim_reg_bank_stack;

    localparam int DW    = 32;
    localparam int NG    = 15;
    localparam int NB    = 15;
    localparam int BW    = 5;
    localparam int GW    = NG * DW;
    localparam int CW    = GW + 5 * DW;
    localparam int WORDS = NG + 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          save_req = 1'b0;
    logic          bank_en = 1'b0;
    logic          restore_req = 1'b0;
    logic [CW-1:0] ctx_drv = '0;
    logic [GW-1:0] gpr_out;
    logic [DW-1:0] gbr_out, mach_out, macl_out, pr_out, vto_out;
    logic [BW-1:0] bank_num;
    logic          overflow, underflow;

    int vectors = 0;
    int errors  = 0;

    logic [CW-1:0] stk [$];
    logic [CW-1:0] out_m = '0;
    bit            ovf_m = 1'b0;
    bit            udf_m = 1'b0;

    always #10 clk = ~clk;

    reg_bank_stack u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .bank_en     (bank_en),
        .restore_req (restore_req),
        .gpr_in      (ctx_drv[GW-1:0]),
        .gbr_in      (ctx_drv[GW+1*DW-1 -: DW]),
        .mach_in     (ctx_drv[GW+2*DW-1 -: DW]),
        .macl_in     (ctx_drv[GW+3*DW-1 -: DW]),
        .pr_in       (ctx_drv[GW+4*DW-1 -: DW]),
        .vto_in      (ctx_drv[GW+5*DW-1 -: DW]),
        .gpr_out     (gpr_out),
        .gbr_out     (gbr_out),
        .mach_out    (mach_out),
        .macl_out    (macl_out),
        .pr_out      (pr_out),
        .vto_out     (vto_out),
        .bank_num    (bank_num),
        .overflow    (overflow),
        .underflow   (underflow)
    );

    // Distinct pattern per context and per word.
    function automatic logic [CW-1:0] mk_ctx(int k);
        logic [CW-1:0] c;
        for (int w = 0; w < WORDS; w++) begin
            c[w*DW +: DW] = {8'(k + 1), 8'(w), 16'(k * 977 + w * 131)};
        end
        return c;
    endfunction

    task automatic compare(string tag);
        logic [CW-1:0] got;
        got = {vto_out, pr_out, macl_out, mach_out, gbr_out, gpr_out};
        vectors++;
        if (bank_num != BW'(stk.size())) begin
            errors++;
            $display("FAIL %s bank_num actual=%0d expected=%0d", tag, bank_num, stk.size());
        end
        if (overflow != ovf_m || underflow != udf_m) begin
            errors++;
            $display("FAIL %s flags actual ovf=%0b udf=%0b expected ovf=%0b udf=%0b",
                     tag, overflow, underflow, ovf_m, udf_m);
        end
        if (got != out_m) begin
            errors++;
            $display("FAIL %s restore data actual=%h expected=%h", tag, got, out_m);
        end
    endtask

    // One clock: drive at falling edge, update model after rising edge,
    // compare at the next falling edge.
    task automatic step(bit s, bit e, bit r, logic [CW-1:0] c, string tag);
        save_req    = s;
        bank_en     = e;
        restore_req = r;
        ctx_drv     = c;
        @(posedge clk);
        #1;
        if (s) begin
            if (e) begin
                if (stk.size() < NB) stk.push_back(c);
                else ovf_m = 1'b1;
            end
        end else if (r) begin
            if (stk.size() > 0) out_m = stk.pop_back();
            else udf_m = 1'b1;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");

        // R2: three qualified saves
        for (int k = 0; k < 3; k++) step(1, 1, 0, mk_ctx(k), "R2 qualified save");
        // R3: unqualified save, then a restore showing bank 2 untouched
        step(1, 0, 0, mk_ctx(50), "R3 unqualified save");
        step(0, 0, 0, '0, "R3 idle");
        step(0, 1, 1, mk_ctx(51), "R4 restore top bank");
        // R7: save and restore together
        step(1, 1, 1, mk_ctx(60), "R7 save wins");
        step(1, 0, 1, mk_ctx(61), "R7 unqualified save masks restore");
        // R4 / R8: drain to empty
        for (int k = 0; k < 3; k++) step(0, 0, 1, '0, "R4 R8 drain");
        // R6: restore while empty
        step(0, 0, 1, '0, "R6 empty restore");
        step(0, 0, 0, '0, "R9 underflow sticky");
        // R10: fill every bank
        for (int k = 0; k < NB; k++) step(1, 1, 0, mk_ctx(100 + k), "R10 fill");
        // R5: overflow attempt must not disturb bank 14
        step(1, 1, 0, mk_ctx(200), "R5 save at full");
        step(0, 0, 0, '0, "R9 overflow sticky");
        // R10 / R8: drain in reverse order
        for (int k = 0; k < NB; k++) step(0, 0, 1, '0, "R10 R8 reverse drain");
        step(0, 0, 0, '0, "R9 flags held");

        // R1: reset again clears everything
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        stk.delete();
        out_m = '0;
        ovf_m = 1'b0;
        udf_m = 1'b0;
        compare("R1 reset after use");
        step(1, 1, 0, mk_ctx(7), "R2 save after reset");
        step(0, 0, 1, '0, "R8 round trip");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule